// File: doc/BRIEF.md
# Dual-Loop Synthesizer Mode and Monitor-Pin Controller

This block holds the digital control of a synthesizer with two phase-locked loops, a high-band loop (RF) and a low-band loop (IF). Two configuration bits from each loop's reference-divider word form a four-bit mode code. The code chooses what one shared monitor pin shows: lock status of either loop or of both, a one-clock pulse from any of the four dividers, the drive for a second loop-filter damping resistor during fast acquisition, or nothing. One code instead holds every divider counter in reset.

The block also watches each loop's phase-detector pulses to decide lock. It steers each loop's up/down pulses to the charge pump according to the VCO slope polarity bit. It forwards the current-level bit and floats a loop's pump when that loop is powered down. It gates the N and reference counters, and the shared reference counter stops only when both loops are powered down. All logic runs on the reference clock and uses a synchronous active-high reset.

Top module: `dual_pll_ctrl`

## Requirements
- R1: The mode code is {rf_mode_bits[1], rf_mode_bits[0], if_mode_bits[1], if_mode_bits[0]}, with values 0 to 12 selecting: off, IF lock, RF lock, both locked, IF reference pulse, RF reference pulse, IF N pulse, RF N pulse, fast acquisition, three reserved codes (9, 10, 11) and counter reset. Reserved codes and codes 13 to 15 drive mon_pin low. mon_pin is registered and reflects its inputs one clock later.
- R2: In the off mode (code 0), mon_pin is driven low whatever the lock state.
- R3: A comparison takes place in each cycle where that loop's ref_tc is high. The phase-error width of a comparison is the number of cycles with pd_up or pd_dn high since the previous comparison. A loop becomes locked at the fourth consecutive comparison whose width is below 2. It leaves lock at the first comparison whose width is 2 or more.
- R4: In a single-loop lock mode (codes 1 and 2), mon_pin is high while that loop is locked. It goes low for each cycle in which that loop's pd_up or pd_dn is high, and it is low while the loop is unlocked.
- R5: In the both-locked mode (code 3), mon_pin is high only when both loops are locked.
- R6: In the divider modes (codes 4 to 7), mon_pin shows a one-cycle high pulse for each cycle in which the selected terminal-count input is high. The other three terminal-count inputs have no effect.
- R7: In fast-acquisition mode (code 8), mon_pin is low while rf_cp_cur is high and high while it is low.
- R8: In counter-reset mode (code 12), cnt_rst is high and ref_cnt_en, if_n_en and rf_n_en are low. All of them return to the running state in the same cycle when the code changes.
- R9: While a loop's pd bit is high, that loop's N-counter enable is low, its cp_hiz is high, its cp_up and cp_dn are low, and its lock state is cleared.
- R10: ref_cnt_en is low when both loops are powered down, and high when only one of them is (outside counter-reset mode).
- R11: With cp_pol high (positive VCO slope), cp_up follows pd_up and cp_dn follows pd_dn. With cp_pol low, the two are swapped.
- R12: cp_hi follows the loop's cp_cur bit while the loop is powered up; high selects full current and low selects one quarter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rf_mode_bits | input | 2 | Mode bits from the RF reference word ([1] is the upper bit) |
| if_mode_bits | input | 2 | Mode bits from the IF reference word |
| rf_pd | input | 1 | RF loop powerdown |
| if_pd | input | 1 | IF loop powerdown |
| rf_cp_cur | input | 1 | RF charge-pump current level (1 = full) |
| if_cp_cur | input | 1 | IF charge-pump current level |
| rf_cp_pol | input | 1 | RF VCO slope polarity (1 = positive) |
| if_cp_pol | input | 1 | IF VCO slope polarity |
| rf_pd_up | input | 1 | RF phase-detector up pulse |
| rf_pd_dn | input | 1 | RF phase-detector down pulse |
| if_pd_up | input | 1 | IF phase-detector up pulse |
| if_pd_dn | input | 1 | IF phase-detector down pulse |
| rf_ref_tc | input | 1 | RF reference-divider terminal count |
| if_ref_tc | input | 1 | IF reference-divider terminal count |
| rf_n_tc | input | 1 | RF N-divider terminal count |
| if_n_tc | input | 1 | IF N-divider terminal count |
| mon_pin | output | 1 | Shared multifunction monitor pin |
| cnt_rst | output | 1 | Reset to all divider counters |
| ref_cnt_en | output | 1 | Reference counter enable |
| rf_n_en | output | 1 | RF N counter enable |
| if_n_en | output | 1 | IF N counter enable |
| rf_cp_up | output | 1 | RF charge-pump up command |
| rf_cp_dn | output | 1 | RF charge-pump down command |
| rf_cp_hiz | output | 1 | RF charge-pump float |
| rf_cp_hi | output | 1 | RF charge-pump full current |
| if_cp_up | output | 1 | IF charge-pump up command |
| if_cp_dn | output | 1 | IF charge-pump down command |
| if_cp_hiz | output | 1 | IF charge-pump float |
| if_cp_hi | output | 1 | IF charge-pump full current |

## Verification
On every cycle, the assertions check the following. A powered-down pump floats with no pulses, and the reference counter stops when both loops sleep. Polarity steering holds. The off, reserved and both-locked modes never raise the pin without cause. A loop enters lock only at a comparison, and a wide comparison or a powerdown always clears it. Only the bench scenarios can show the exact count of four narrow comparisons before lock, the narrow low pulses, the timing of the one-cycle divider pulses, and the simultaneous release of all counters after counter-reset mode.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;

    localparam int NUM_LOOPS = 2;
    localparam int LOOP_IF   = 0;
    localparam int LOOP_RF   = 1;

    typedef enum logic [3:0] {
        PIN_OFF       = 4'd0,
        PIN_IF_LOCK   = 4'd1,
        PIN_RF_LOCK   = 4'd2,
        PIN_BOTH_LOCK = 4'd3,
        PIN_IF_REF    = 4'd4,
        PIN_RF_REF    = 4'd5,
        PIN_IF_N      = 4'd6,
        PIN_RF_N      = 4'd7,
        PIN_FAST      = 4'd8,
        PIN_RSV_A     = 4'd9,
        PIN_RSV_B     = 4'd10,
        PIN_RSV_C     = 4'd11,
        PIN_CNT_RST   = 4'd12
    } pin_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic hiz;
        logic hi;
    } cp_cmd_t;

    function automatic logic [3:0] mode_code(input logic [1:0] rf_bits,
                                             input logic [1:0] if_bits);
        return {rf_bits, if_bits};
    endfunction

endpackage

// File: rtl/lock_monitor.sv
module lock_monitor
    import pll_ctrl_pkg::*;
#(
    parameter int LOCK_WIDTH = 2,
    parameter int LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic err,
    input  logic strobe,
    output logic locked
);
    localparam int WCNT_W = $clog2(LOCK_WIDTH + 1);
    localparam int GOOD_W = $clog2(LOCK_COUNT + 1);

    logic [WCNT_W-1:0] wcnt;
    logic [GOOD_W-1:0] good;
    logic [WCNT_W:0]   w_sum;
    logic              narrow;
    logic              last_good;

    always_comb begin
        w_sum     = {1'b0, wcnt} + {{WCNT_W{1'b0}}, err};
        narrow    = w_sum < (WCNT_W+1)'(LOCK_WIDTH);
        last_good = (good == GOOD_W'(LOCK_COUNT - 1)) || (good == GOOD_W'(LOCK_COUNT));
    end

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            wcnt   <= '0;
            good   <= '0;
            locked <= 1'b0;
        end else if (strobe) begin
            wcnt <= '0;
            if (narrow) begin
                if (good != GOOD_W'(LOCK_COUNT)) good <= good + 1'b1;
                locked <= last_good;
            end else begin
                good   <= '0;
                locked <= 1'b0;
            end
        end else if (err && (wcnt != WCNT_W'(LOCK_WIDTH))) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // R3: lock can only appear right after a comparison
    a_r3_lock_at_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(strobe));

    // R3: a comparison already known to be wide removes lock
    a_r3_wide_drops: assert property (@(posedge clk) disable iff (rst)
        (strobe && !pd && wcnt >= WCNT_W'(LOCK_WIDTH)) |=> !locked);

    // R9: powerdown clears lock
    a_r9_pd_clears: assert property (@(posedge clk) disable iff (rst)
        pd |=> !locked);

endmodule

// File: rtl/cp_steer.sv
module cp_steer
    import pll_ctrl_pkg::*;
(
    input  logic    pd,
    input  logic    cur,
    input  logic    pol,
    input  logic    pd_up,
    input  logic    pd_dn,
    output cp_cmd_t cmd
);
    always_comb begin
        cmd = '0;
        if (pd) begin
            cmd.hiz = 1'b1;
        end else begin
            cmd.up = pol ? pd_up : pd_dn;
            cmd.dn = pol ? pd_dn : pd_up;
            cmd.hi = cur;
        end
    end
endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import pll_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           code,
    input  logic [NUM_LOOPS-1:0] locked,
    input  logic [NUM_LOOPS-1:0] err,
    input  logic [NUM_LOOPS-1:0] ref_tc,
    input  logic [NUM_LOOPS-1:0] n_tc,
    input  logic                 rf_cur,
    output logic                 pin,
    output logic                 cnt_rst
);
    logic pin_d;
    logic both_ok;

    always_comb begin
        both_ok = locked[LOOP_IF] && locked[LOOP_RF];
        cnt_rst = (code == PIN_CNT_RST);
        case (code)
            PIN_IF_LOCK:   pin_d = locked[LOOP_IF] && !err[LOOP_IF];
            PIN_RF_LOCK:   pin_d = locked[LOOP_RF] && !err[LOOP_RF];
            PIN_BOTH_LOCK: pin_d = both_ok && !(|err);
            PIN_IF_REF:    pin_d = ref_tc[LOOP_IF];
            PIN_RF_REF:    pin_d = ref_tc[LOOP_RF];
            PIN_IF_N:      pin_d = n_tc[LOOP_IF];
            PIN_RF_N:      pin_d = n_tc[LOOP_RF];
            PIN_FAST:      pin_d = !rf_cur;
            default:       pin_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= pin_d;
    end

    // R2: off mode keeps the pin low
    a_r2_off_low: assert property (@(posedge clk) disable iff (rst)
        (code == PIN_OFF) |=> !pin);

    // R1: reserved and unused codes keep the pin low
    a_r1_unused_low: assert property (@(posedge clk) disable iff (rst)
        ((code >= PIN_RSV_A && code <= PIN_RSV_C) || code > PIN_CNT_RST) |=> !pin);

    // R5: combined mode needs both loops locked
    a_r5_both_needed: assert property (@(posedge clk) disable iff (rst)
        (code == PIN_BOTH_LOCK && !both_ok) |=> !pin);

endmodule

// File: rtl/dual_pll_ctrl.sv
module dual_pll_ctrl
    import pll_ctrl_pkg::*;
#(
    parameter int LOCK_WIDTH = 2,
    parameter int LOCK_COUNT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rf_mode_bits,
    input  logic [1:0] if_mode_bits,
    input  logic       rf_pd,
    input  logic       if_pd,
    input  logic       rf_cp_cur,
    input  logic       if_cp_cur,
    input  logic       rf_cp_pol,
    input  logic       if_cp_pol,
    input  logic       rf_pd_up,
    input  logic       rf_pd_dn,
    input  logic       if_pd_up,
    input  logic       if_pd_dn,
    input  logic       rf_ref_tc,
    input  logic       if_ref_tc,
    input  logic       rf_n_tc,
    input  logic       if_n_tc,
    output logic       mon_pin,
    output logic       cnt_rst,
    output logic       ref_cnt_en,
    output logic       rf_n_en,
    output logic       if_n_en,
    output logic       rf_cp_up,
    output logic       rf_cp_dn,
    output logic       rf_cp_hiz,
    output logic       rf_cp_hi,
    output logic       if_cp_up,
    output logic       if_cp_dn,
    output logic       if_cp_hiz,
    output logic       if_cp_hi
);
    logic [NUM_LOOPS-1:0] pd_v, cur_v, pol_v, up_v, dn_v, rtc_v, ntc_v;
    logic [NUM_LOOPS-1:0] err_v, lock_v;
    cp_cmd_t              cmd_v [NUM_LOOPS];
    logic [3:0]           code;

    assign pd_v  = {rf_pd,     if_pd};
    assign cur_v = {rf_cp_cur, if_cp_cur};
    assign pol_v = {rf_cp_pol, if_cp_pol};
    assign up_v  = {rf_pd_up,  if_pd_up};
    assign dn_v  = {rf_pd_dn,  if_pd_dn};
    assign rtc_v = {rf_ref_tc, if_ref_tc};
    assign ntc_v = {rf_n_tc,   if_n_tc};
    assign code  = mode_code(rf_mode_bits, if_mode_bits);

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        assign err_v[g] = up_v[g] | dn_v[g];

        lock_monitor #(
            .LOCK_WIDTH(LOCK_WIDTH),
            .LOCK_COUNT(LOCK_COUNT)
        ) u_lock (
            .clk   (clk),
            .rst   (rst),
            .pd    (pd_v[g]),
            .err   (err_v[g]),
            .strobe(rtc_v[g]),
            .locked(lock_v[g])
        );

        cp_steer u_cp (
            .pd   (pd_v[g]),
            .cur  (cur_v[g]),
            .pol  (pol_v[g]),
            .pd_up(up_v[g]),
            .pd_dn(dn_v[g]),
            .cmd  (cmd_v[g])
        );
    end

    pin_mux u_mux (
        .clk    (clk),
        .rst    (rst),
        .code   (code),
        .locked (lock_v),
        .err    (err_v),
        .ref_tc (rtc_v),
        .n_tc   (ntc_v),
        .rf_cur (rf_cp_cur),
        .pin    (mon_pin),
        .cnt_rst(cnt_rst)
    );

    assign ref_cnt_en = !(rf_pd && if_pd) && !cnt_rst;
    assign rf_n_en    = !rf_pd && !cnt_rst;
    assign if_n_en    = !if_pd && !cnt_rst;

    assign rf_cp_up  = cmd_v[LOOP_RF].up;
    assign rf_cp_dn  = cmd_v[LOOP_RF].dn;
    assign rf_cp_hiz = cmd_v[LOOP_RF].hiz;
    assign rf_cp_hi  = cmd_v[LOOP_RF].hi;
    assign if_cp_up  = cmd_v[LOOP_IF].up;
    assign if_cp_dn  = cmd_v[LOOP_IF].dn;
    assign if_cp_hiz = cmd_v[LOOP_IF].hiz;
    assign if_cp_hi  = cmd_v[LOOP_IF].hi;

    // R10: reference counter halts with both loops asleep
    a_r10_ref_stop: assert property (@(posedge clk) disable iff (rst)
        (rf_pd && if_pd) |-> !ref_cnt_en);

    // R9: a sleeping loop's pump floats and issues no pulses
    a_r9_rf_float: assert property (@(posedge clk) disable iff (rst)
        rf_pd |-> (rf_cp_hiz && !rf_cp_up && !rf_cp_dn && !rf_n_en));
    a_r9_if_float: assert property (@(posedge clk) disable iff (rst)
        if_pd |-> (if_cp_hiz && !if_cp_up && !if_cp_dn && !if_n_en));

    // R11: negative slope swaps the pulses
    a_r11_rf_swap: assert property (@(posedge clk) disable iff (rst)
        (!rf_pd && !rf_cp_pol) |-> (rf_cp_up == rf_pd_dn && rf_cp_dn == rf_pd_up));

    // R8: counter reset stops every counter
    a_r8_all_held: assert property (@(posedge clk) disable iff (rst)
        cnt_rst |-> (!ref_cnt_en && !rf_n_en && !if_n_en));

endmodule

// File: tb/test_dual_pll_ctrl.sv
module test_dual_pll_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] rf_mode_bits = 2'b00, if_mode_bits = 2'b00;
    logic rf_pd = 0, if_pd = 0, rf_cp_cur = 0, if_cp_cur = 0;
    logic rf_cp_pol = 1, if_cp_pol = 1;
    logic rf_pd_up = 0, rf_pd_dn = 0, if_pd_up = 0, if_pd_dn = 0;
    logic rf_ref_tc = 0, if_ref_tc = 0, rf_n_tc = 0, if_n_tc = 0;
    logic mon_pin, cnt_rst, ref_cnt_en, rf_n_en, if_n_en;
    logic rf_cp_up, rf_cp_dn, rf_cp_hiz, rf_cp_hi;
    logic if_cp_up, if_cp_dn, if_cp_hiz, if_cp_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_pll_ctrl i_dual_pll_ctrl (
        .clk(clk), .rst(rst),
        .rf_mode_bits(rf_mode_bits), .if_mode_bits(if_mode_bits),
        .rf_pd(rf_pd), .if_pd(if_pd),
        .rf_cp_cur(rf_cp_cur), .if_cp_cur(if_cp_cur),
        .rf_cp_pol(rf_cp_pol), .if_cp_pol(if_cp_pol),
        .rf_pd_up(rf_pd_up), .rf_pd_dn(rf_pd_dn),
        .if_pd_up(if_pd_up), .if_pd_dn(if_pd_dn),
        .rf_ref_tc(rf_ref_tc), .if_ref_tc(if_ref_tc),
        .rf_n_tc(rf_n_tc), .if_n_tc(if_n_tc),
        .mon_pin(mon_pin), .cnt_rst(cnt_rst), .ref_cnt_en(ref_cnt_en),
        .rf_n_en(rf_n_en), .if_n_en(if_n_en),
        .rf_cp_up(rf_cp_up), .rf_cp_dn(rf_cp_dn), .rf_cp_hiz(rf_cp_hiz), .rf_cp_hi(rf_cp_hi),
        .if_cp_up(if_cp_up), .if_cp_dn(if_cp_dn), .if_cp_hiz(if_cp_hiz), .if_cp_hi(if_cp_hi)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock; inputs are driven and outputs sampled 1 ns after the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic [3:0] c);
        {rf_mode_bits, if_mode_bits} = c;
    endtask

    // one comparison with an error pulse of the given width
    task automatic cmp(input bit rf, input int width);
        for (int i = 0; i < width; i++) begin
            if (rf) rf_pd_up = 1; else if_pd_up = 1;
            tick();
        end
        rf_pd_up = 0; if_pd_up = 0;
        tick();
        if (rf) rf_ref_tc = 1; else if_ref_tc = 1;
        tick();
        rf_ref_tc = 0; if_ref_tc = 0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 reset pin", mon_pin, 1'b0);
        chk("R8 reset cnt_rst", cnt_rst, 1'b0);
        chk("R10 reset ref_en", ref_cnt_en, 1'b1);
    endtask

    task automatic t_lock_if();
        set_mode(4'd1);
        for (int k = 0; k < 3; k++) cmp(0, 1);
        chk("R3 three narrow not locked", mon_pin, 1'b0);
        cmp(0, 1);
        chk("R3 fourth narrow locks", mon_pin, 1'b1);
        if_pd_dn = 1; tick();
        chk("R4 low during error pulse", mon_pin, 1'b0);
        if_pd_dn = 0; tick();
        chk("R4 high again after pulse", mon_pin, 1'b1);
        cmp(0, 3);
        chk("R3 wide comparison drops", mon_pin, 1'b0);
        for (int k = 0; k < 4; k++) cmp(0, 1);
        chk("R3 relock", mon_pin, 1'b1);
        cmp(0, 2);
        chk("R3 width two is wide", mon_pin, 1'b0);
        for (int k = 0; k < 4; k++) cmp(0, 0);
        chk("R3 relock zero width", mon_pin, 1'b1);
    endtask

    task automatic t_both();
        set_mode(4'd3); tick(); tick();
        chk("R5 RF unlocked gives low", mon_pin, 1'b0);
        for (int k = 0; k < 4; k++) cmp(1, 1);
        chk("R5 both locked gives high", mon_pin, 1'b1);
        set_mode(4'd2); tick(); tick();
        chk("R4 RF lock mode high", mon_pin, 1'b1);
        set_mode(4'd0); tick(); tick();
        chk("R2 off mode low while locked", mon_pin, 1'b0);
    endtask

    task automatic t_reserved();
        for (int c = 9; c < 16; c++) begin
            if (c == 12) continue;
            set_mode(4'(c)); tick(); tick();
            chk("R1 reserved or unused code low", mon_pin, 1'b0);
            chk("R1 reserved code no counter reset", cnt_rst, 1'b0);
        end
    endtask

    task automatic t_div();
        set_mode(4'd4); tick();
        rf_ref_tc = 1; rf_n_tc = 1; if_n_tc = 1; tick();
        rf_ref_tc = 0; rf_n_tc = 0; if_n_tc = 0; tick();
        chk("R6 other terminal counts ignored", mon_pin, 1'b0);
        if_ref_tc = 1; tick();
        chk("R6 IF ref pulse high", mon_pin, 1'b1);
        if_ref_tc = 0; tick();
        chk("R6 IF ref pulse one cycle", mon_pin, 1'b0);
        set_mode(4'd5); rf_ref_tc = 1; tick();
        chk("R6 RF ref pulse", mon_pin, 1'b1);
        rf_ref_tc = 0;
        set_mode(4'd6); if_n_tc = 1; tick();
        chk("R6 IF N pulse", mon_pin, 1'b1);
        if_n_tc = 0;
        set_mode(4'd7); rf_n_tc = 1; tick();
        chk("R6 RF N pulse", mon_pin, 1'b1);
        rf_n_tc = 0; tick();
        chk("R6 RF N pulse ends", mon_pin, 1'b0);
    endtask

    task automatic t_fast();
        set_mode(4'd8); rf_cp_cur = 1; tick();
        chk("R7 fast pin low with full current", mon_pin, 1'b0);
        rf_cp_cur = 0; tick();
        chk("R7 fast pin high with low current", mon_pin, 1'b1);
    endtask

    task automatic t_cnt_rst();
        set_mode(4'd12); #1;
        chk("R8 cnt_rst high", cnt_rst, 1'b1);
        chk("R8 ref counter held", ref_cnt_en, 1'b0);
        chk("R8 RF N held", rf_n_en, 1'b0);
        chk("R8 IF N held", if_n_en, 1'b0);
        tick();
        chk("R8 pin low", mon_pin, 1'b0);
        set_mode(4'd0); #1;
        chk("R8 release cnt_rst", cnt_rst, 1'b0);
        chk("R8 release ref", ref_cnt_en, 1'b1);
        chk("R8 release RF N", rf_n_en, 1'b1);
        chk("R8 release IF N", if_n_en, 1'b1);
    endtask

    task automatic t_pd();
        set_mode(4'd1); tick(); tick();
        chk("R9 IF locked before pd", mon_pin, 1'b1);
        if_pd = 1; if_pd_up = 1; #1;
        chk("R9 IF hiz", if_cp_hiz, 1'b1);
        chk("R9 IF no up", if_cp_up, 1'b0);
        chk("R9 IF N disabled", if_n_en, 1'b0);
        chk("R10 one loop down ref runs", ref_cnt_en, 1'b1);
        if_pd_up = 0;
        tick(); tick();
        if_pd = 0; tick(); tick();
        chk("R9 lock cleared by pd", mon_pin, 1'b0);
        rf_pd = 1; if_pd = 1; #1;
        chk("R10 both down ref stops", ref_cnt_en, 1'b0);
        chk("R9 RF hiz", rf_cp_hiz, 1'b1);
        rf_pd = 0; if_pd = 0; #1;
        chk("R10 ref resumes", ref_cnt_en, 1'b1);
    endtask

    task automatic t_pump();
        rf_cp_pol = 1; rf_pd_up = 1; rf_cp_cur = 1; #1;
        chk("R11 positive up", rf_cp_up, 1'b1);
        chk("R11 positive dn", rf_cp_dn, 1'b0);
        chk("R12 full current", rf_cp_hi, 1'b1);
        rf_cp_pol = 0; #1;
        chk("R11 negative up", rf_cp_up, 1'b0);
        chk("R11 negative dn", rf_cp_dn, 1'b1);
        rf_cp_cur = 0; #1;
        chk("R12 quarter current", rf_cp_hi, 1'b0);
        rf_pd_up = 0; if_cp_pol = 0; if_pd_dn = 1; if_cp_cur = 1; #1;
        chk("R11 IF swapped up", if_cp_up, 1'b1);
        chk("R12 IF full current", if_cp_hi, 1'b1);
        if_pd_dn = 0; rf_cp_pol = 1; if_cp_pol = 1;
        tick();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        t_reset();
        t_lock_if();
        t_both();
        t_reserved();
        t_div();
        t_fast();
        t_cnt_rst();
        for (int k = 0; k < 4; k++) cmp(0, 1);
        t_pd();
        t_pump();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule